// File: doc/BRIEF.md
# External Asynchronous Bus Controller

This block turns internal transfer requests into cycles on an external asynchronous memory bus. An internal requester presents a transfer (direction, size, 20-bit start address, region select and write data) and the controller runs it as a sequence of port-width beats. It drives the address bus, the data bus, two active-high chip-select lines, an output enable and a read/write line. When the last beat has finished, it returns a one-cycle acknowledge together with the assembled read data.

The bus has two modes. In the separate mode, the address goes out on the address bus and the data moves over its own 8-bit bus. In the shared mode, address and data use the low pins of the address bus. Each beat then opens with a one-cycle address-latch strobe, which is carried on chip-select line 1, and only chip-select line 0 remains available as a select. The shared mode can run with an 8-bit or a 16-bit port. Before each chip-select pulse the address is held for a programmable number of setup cycles. After the pulse the address and the direction line are held for a programmable number of hold cycles. Mode, width, setup and hold are captured when a request is accepted.

Sequencer states: ST_IDLE (ready), ST_ADDR (latch strobe, shared mode only), ST_SETUP (address valid, no select), ST_STROBE (select pulse for one cycle, data moves), ST_HOLD (address and direction held), ST_DONE (acknowledge). The transitions are as follows.
- accept: ST_IDLE moves to ST_ADDR, ST_SETUP or ST_STROBE.
- latch: ST_ADDR moves to ST_SETUP or ST_STROBE.
- setup expiry: ST_SETUP moves to ST_STROBE.
- strobe end: ST_STROBE moves to ST_HOLD, or takes the beat-end step.
- hold expiry: ST_HOLD takes the beat-end step.
- beat-end step: goes to the next beat (ST_ADDR, ST_SETUP or ST_STROBE), or to ST_DONE after the final beat.
- finish: ST_DONE moves to ST_IDLE.

Top module: `extbus_ctrl`

## Requirements
- R1: `ready_o` is high only while the controller is idle. A request is accepted on a clock edge where `req_i` and `ready_o` are both high, and `ready_o` is low in the next cycle. `ack_o` is high for exactly one cycle after the final beat, and `rdata_o` is valid in that cycle. `ready_o` returns high in the cycle after `ack_o`.
- R2: `req_size_i` selects the transfer length: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 16 bytes. A beat is 2 bytes only for a multi-byte transfer in the shared mode with the 16-bit port; every other beat is 1 byte. The transfer issues exactly (length / beat bytes) select pulses before `ack_o`.
- R3: In the separate mode (`cfg_mux_i`=0), the port is 8 bits wide whatever `cfg_wide_i` holds. Write bytes appear on `bus_d_o` during the select pulse, and read bytes are taken from `bus_d_i`.
- R4: Beat k uses the address start + k × (beat bytes), modulo 2^20. Data is big-endian: the write data sits in `req_wdata_i[8N-1:0]`, and its most significant byte goes to the first address. Read data is assembled the same way into `rdata_o[8N-1:0]`, with the upper bits zero.
- R5: Every beat holds its address on `bus_a_o` with no select asserted for `cfg_setup_i` cycles (0 to 7), and then asserts its select for exactly one cycle.
- R6: After each select pulse, `bus_a_o` keeps the beat address and `bus_rw_o` keeps its level for `cfg_hold_i` cycles (0 to 7), with no select asserted.
- R7: `bus_rw_o` is 0 from the first beat cycle through the last hold cycle of a write, and 1 at all other times.
- R8: `bus_oe_o` is high only in the select cycle of read beats.
- R9: In the shared mode, each beat begins with one cycle in which `bus_cs_o`=2'b10 and `bus_a_o` carries the beat address. Then come the setup cycles. The select pulse is always `bus_cs_o`=2'b01, whatever the region. Write data goes out on the low pins of `bus_a_o`: `{addr[19:16], data16}` with the 16-bit port and `{addr[19:8], byte}` with the 8-bit port. Reads take data from `bus_a_i`, and `bus_d_o` stays 0.
- R10: With the 16-bit shared port, a 2-byte beat places the byte at the lower address on bits [15:8]. A byte write drives its byte on both lanes. A byte read takes `bus_a_i[15:8]` when address bit 0 is 0, and `bus_a_i[7:0]` when it is 1.
- R11: In the separate mode, region 0 pulses `bus_cs_o[0]` and region 1 pulses `bus_cs_o[1]`.
- R12: During reset, `ready_o`=1, `ack_o`=0, `bus_cs_o`=0, `bus_oe_o`=0, `bus_rw_o`=1, `bus_a_o`=0 and `bus_d_o`=0.
- R13: While idle and during the acknowledge cycle, `bus_a_o`, `bus_d_o` and `bus_cs_o` are 0. `bus_d_o` is nonzero only in a select cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Transfer length code |
| req_addr_i | input | 20 | Start byte address |
| req_region_i | input | 1 | Select line for the separate mode |
| req_wdata_i | input | 128 | Write data, right-aligned, big-endian |
| cfg_mux_i | input | 1 | 1 = shared address/data pins |
| cfg_wide_i | input | 1 | 1 = 16-bit port (shared mode only) |
| cfg_setup_i | input | 3 | Setup cycles before the select pulse |
| cfg_hold_i | input | 3 | Hold cycles after the select pulse |
| ready_o | output | 1 | Idle, will accept a request |
| ack_o | output | 1 | Transfer complete, one cycle |
| rdata_o | output | 128 | Assembled read data |
| bus_a_o | output | 20 | Address bus, or address/data in the shared mode |
| bus_a_i | input | 16 | Low address pins read back in the shared mode |
| bus_d_o | output | 8 | Separate write data bus |
| bus_d_i | input | 8 | Separate read data bus |
| bus_cs_o | output | 2 | Selects, active high; line 1 is the latch strobe in the shared mode |
| bus_oe_o | output | 1 | Output enable |
| bus_rw_o | output | 1 | 1 = read, 0 = write |

## Verification
A corrupt setup or hold counter would show at once as a select pulse that arrives a cycle early or late against the address, so the bench compares every bus pin in every cycle of every beat. A wrong beat counter or beat width would change the number of pulses, or move `ack_o` a whole beat earlier or later. A bad address increment or data shift would first appear on the next beat's address or data lane, and for reads in the acknowledge cycle as a misplaced byte in `rdata_o`. A stale mode or region latch would put the select pulse on the wrong line, or the data on the wrong pins, in the first select cycle of the transfer.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LINE = 2'd3
    } xfer_size_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4,
        ST_DONE   = 3'd5
    } bus_state_e;

endpackage

// File: rtl/extbus_plan.sv
module extbus_plan
    import extbus_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    localparam int BC_W = $clog2(LINE_BYTES) + 1
) (
    input  xfer_size_e        size_i,
    input  logic              wide16_i,
    output logic [BC_W-1:0]   nbytes_o,
    output logic [BC_W-1:0]   beats_o,
    output logic              two_o
);
    always_comb begin
        unique case (size_i)
            SZ_BYTE: nbytes_o = BC_W'(1);
            SZ_WORD: nbytes_o = BC_W'(2);
            SZ_LONG: nbytes_o = BC_W'(4);
            SZ_LINE: nbytes_o = BC_W'(LINE_BYTES);
            default: nbytes_o = BC_W'(1);
        endcase
        // two-byte beats only when the port is 16 bits and the transfer is wider than a byte
        two_o   = wide16_i && (size_i != SZ_BYTE);
        beats_o = two_o ? (nbytes_o >> 1) : nbytes_o;
    end
endmodule

// File: rtl/extbus_fsm.sv
module extbus_fsm
    import extbus_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mux_i,
    input  logic [CW-1:0] setup_i,
    input  logic [CW-1:0] hold_i,
    input  logic          last_i,
    output bus_state_e    state_o,
    output logic          mux_q_o,
    output logic          step_o
);
    bus_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] setup_q, hold_q;
    logic          mux_q;

    // entry point of the following beat
    bus_state_e    beat_st;
    logic [CW-1:0] beat_cnt;

    always_comb begin
        if (last_i) begin
            beat_st  = ST_DONE;
            beat_cnt = cnt_q;
        end else if (mux_q) begin
            beat_st  = ST_ADDR;
            beat_cnt = cnt_q;
        end else if (setup_q != '0) begin
            beat_st  = ST_SETUP;
            beat_cnt = setup_q;
        end else begin
            beat_st  = ST_STROBE;
            beat_cnt = cnt_q;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (mux_i) begin
                        state_d = ST_ADDR;
                    end else if (setup_i != '0) begin
                        state_d = ST_SETUP;
                        cnt_d   = setup_i;
                    end else begin
                        state_d = ST_STROBE;
                    end
                end
            end
            ST_ADDR: begin
                if (setup_q != '0) begin
                    state_d = ST_SETUP;
                    cnt_d   = setup_q;
                end else begin
                    state_d = ST_STROBE;
                end
            end
            ST_SETUP: begin
                if (cnt_q == CW'(1)) state_d = ST_STROBE;
                else                 cnt_d   = cnt_q - CW'(1);
            end
            ST_STROBE: begin
                if (hold_q != '0) begin
                    state_d = ST_HOLD;
                    cnt_d   = hold_q;
                end else begin
                    state_d = beat_st;
                    cnt_d   = beat_cnt;
                end
            end
            ST_HOLD: begin
                if (cnt_q == CW'(1)) begin
                    state_d = beat_st;
                    cnt_d   = beat_cnt;
                end else begin
                    cnt_d   = cnt_q - CW'(1);
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            setup_q <= '0;
            hold_q  <= '0;
            mux_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_IDLE && start_i) begin
                setup_q <= setup_i;
                hold_q  <= hold_i;
                mux_q   <= mux_i;
            end
        end
    end

    assign state_o = state_q;
    assign mux_q_o = mux_q;
    assign step_o  = ((state_q == ST_STROBE) && (hold_q == '0)) ||
                     ((state_q == ST_HOLD) && (cnt_q == CW'(1)));
endmodule

// File: rtl/extbus_data.sv
module extbus_data #(
    parameter int AW         = 20,
    parameter int LINE_BYTES = 16,
    localparam int DW   = 8 * LINE_BYTES,
    localparam int BC_W = $clog2(LINE_BYTES) + 1,
    localparam int SH_W = $clog2(DW) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic            cap_i,
    input  logic            mux_q_i,
    input  logic            we_i,
    input  logic            region_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic            wide_i,
    input  logic            two_i,
    input  logic [BC_W-1:0] nbytes_i,
    input  logic [BC_W-1:0] beats_i,
    input  logic [15:0]     ad_in_i,
    input  logic [7:0]      d_in_i,
    output logic [AW-1:0]   addr_o,
    output logic            last_o,
    output logic            we_o,
    output logic            region_o,
    output logic            wide_o,
    output logic [7:0]      wbyte_o,
    output logic [15:0]     wword_o,
    output logic [DW-1:0]   rdata_o
);
    logic [AW-1:0]   addr_q;
    logic [BC_W-1:0] beats_q;
    logic [DW-1:0]   wsh_q, racc_q;
    logic            we_q, region_q, wide_q, two_q;
    logic [SH_W-1:0] pad_sh;
    logic [7:0]      rd_byte;

    // left-align the write data so the first beat always sits at the top
    assign pad_sh = SH_W'(DW - 8 * int'(nbytes_i));

    always_comb begin
        if (!mux_q_i)    rd_byte = d_in_i;
        else if (wide_q) rd_byte = addr_q[0] ? ad_in_i[7:0] : ad_in_i[15:8];
        else             rd_byte = ad_in_i[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            beats_q  <= '0;
            wsh_q    <= '0;
            racc_q   <= '0;
            we_q     <= 1'b0;
            region_q <= 1'b0;
            wide_q   <= 1'b0;
            two_q    <= 1'b0;
        end else if (load_i) begin
            addr_q   <= addr_i;
            beats_q  <= beats_i;
            wsh_q    <= wdata_i << pad_sh;
            racc_q   <= '0;
            we_q     <= we_i;
            region_q <= region_i;
            wide_q   <= wide_i;
            two_q    <= two_i;
        end else begin
            if (cap_i && !we_q) begin
                racc_q <= two_q ? {racc_q[DW-17:0], ad_in_i} : {racc_q[DW-9:0], rd_byte};
            end
            if (step_i) begin
                addr_q  <= addr_q + (two_q ? AW'(2) : AW'(1));
                beats_q <= beats_q - BC_W'(1);
                wsh_q   <= two_q ? (wsh_q << 16) : (wsh_q << 8);
            end
        end
    end

    assign addr_o   = addr_q;
    assign last_o   = (beats_q == BC_W'(1));
    assign we_o     = we_q;
    assign region_o = region_q;
    assign wide_o   = wide_q;
    assign wbyte_o  = wsh_q[DW-1 -: 8];
    assign wword_o  = two_q ? wsh_q[DW-1 -: 16] : {wsh_q[DW-1 -: 8], wsh_q[DW-1 -: 8]};
    assign rdata_o  = racc_q;
endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
    import extbus_pkg::*;
#(
    parameter int AW         = 20,
    parameter int LINE_BYTES = 16,
    parameter int CW         = 3,
    localparam int DW   = 8 * LINE_BYTES,
    localparam int BC_W = $clog2(LINE_BYTES) + 1,
    localparam int NCS  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic            req_we_i,
    input  logic [1:0]      req_size_i,
    input  logic [AW-1:0]   req_addr_i,
    input  logic            req_region_i,
    input  logic [DW-1:0]   req_wdata_i,
    input  logic            cfg_mux_i,
    input  logic            cfg_wide_i,
    input  logic [CW-1:0]   cfg_setup_i,
    input  logic [CW-1:0]   cfg_hold_i,
    output logic            ready_o,
    output logic            ack_o,
    output logic [DW-1:0]   rdata_o,
    output logic [AW-1:0]   bus_a_o,
    input  logic [15:0]     bus_a_i,
    output logic [7:0]      bus_d_o,
    input  logic [7:0]      bus_d_i,
    output logic [NCS-1:0]  bus_cs_o,
    output logic            bus_oe_o,
    output logic            bus_rw_o
);
    bus_state_e      st;
    logic            start, mux_q, step, last;
    logic            wide_eff, two;
    logic [BC_W-1:0] nbytes, beats;
    logic [AW-1:0]   addr_q;
    logic            we_q, region_q, wide_q;
    logic [7:0]      wbyte;
    logic [15:0]     wword;
    logic            in_xfer;

    assign start    = req_i && (st == ST_IDLE);
    assign wide_eff = cfg_wide_i && cfg_mux_i;

    extbus_plan #(.LINE_BYTES(LINE_BYTES)) u_plan (
        .size_i   (xfer_size_e'(req_size_i)),
        .wide16_i (wide_eff),
        .nbytes_o (nbytes),
        .beats_o  (beats),
        .two_o    (two)
    );

    extbus_fsm #(.CW(CW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .mux_i   (cfg_mux_i),
        .setup_i (cfg_setup_i),
        .hold_i  (cfg_hold_i),
        .last_i  (last),
        .state_o (st),
        .mux_q_o (mux_q),
        .step_o  (step)
    );

    extbus_data #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (start),
        .step_i   (step),
        .cap_i    (st == ST_STROBE),
        .mux_q_i  (mux_q),
        .we_i     (req_we_i),
        .region_i (req_region_i),
        .addr_i   (req_addr_i),
        .wdata_i  (req_wdata_i),
        .wide_i   (wide_eff),
        .two_i    (two),
        .nbytes_i (nbytes),
        .beats_i  (beats),
        .ad_in_i  (bus_a_i),
        .d_in_i   (bus_d_i),
        .addr_o   (addr_q),
        .last_o   (last),
        .we_o     (we_q),
        .region_o (region_q),
        .wide_o   (wide_q),
        .wbyte_o  (wbyte),
        .wword_o  (wword),
        .rdata_o  (rdata_o)
    );

    // select decode: line 1 doubles as the latch strobe in the shared mode
    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign bus_cs_o[g] = ((st == ST_STROBE) && (mux_q ? (g == 0) : (region_q == 1'(g))))
                           || ((g == 1) && (st == ST_ADDR));
    end

    always_comb begin
        in_xfer  = (st == ST_ADDR) || (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
        ready_o  = (st == ST_IDLE);
        ack_o    = (st == ST_DONE);
        bus_rw_o = !(in_xfer && we_q);
        bus_oe_o = (st == ST_STROBE) && !we_q;
        bus_a_o  = in_xfer ? addr_q : '0;
        bus_d_o  = '0;
        if ((st == ST_STROBE) && we_q) begin
            if (mux_q) begin
                bus_a_o = wide_q ? {addr_q[AW-1:16], wword} : {addr_q[AW-1:8], wbyte};
            end else begin
                bus_d_o = wbyte;
            end
        end
    end
endmodule

// File: rtl/extbus_chk.sv
module extbus_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_i,
    input logic       ready_o,
    input logic       ack_o,
    input logic [1:0] bus_cs_o,
    input logic       bus_oe_o,
    input logic       bus_rw_o,
    input logic [7:0] bus_d_o
);
    assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_cs_o));

    assert_oe_read_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> (bus_rw_o && (bus_cs_o != 2'b00)));

    assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ready_o) |=> !ready_o);

    assert_dout_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_d_o != 8'h00) |-> ((bus_cs_o != 2'b00) && !bus_rw_o));

    assert_ack_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (bus_rw_o && (bus_cs_o == 2'b00)));
endmodule

bind extbus_ctrl extbus_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .ready_o  (ready_o),
    .ack_o    (ack_o),
    .bus_cs_o (bus_cs_o),
    .bus_oe_o (bus_oe_o),
    .bus_rw_o (bus_rw_o),
    .bus_d_o  (bus_d_o)
);

// File: tb/tb_extbus_ctrl.sv
module tb_extbus_ctrl;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_i = 1'b0, req_we_i = 1'b0, req_region_i = 1'b0;
    logic [1:0]   req_size_i = '0;
    logic [19:0]  req_addr_i = '0;
    logic [127:0] req_wdata_i = '0;
    logic         cfg_mux_i = 1'b0, cfg_wide_i = 1'b0;
    logic [2:0]   cfg_setup_i = '0, cfg_hold_i = '0;
    logic         ready_o, ack_o, bus_oe_o, bus_rw_o;
    logic [127:0] rdata_o;
    logic [19:0]  bus_a_o;
    logic [15:0]  bus_a_i;
    logic [7:0]   bus_d_o, bus_d_i;
    logic [1:0]   bus_cs_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extbus_ctrl dut (.*);

    function automatic logic [7:0] memb(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h3} ^ 8'hA5;
    endfunction

    // external memory model answering from the address pins
    always_comb begin
        if (cfg_wide_i) bus_a_i = {memb({bus_a_o[19:1], 1'b0}), memb({bus_a_o[19:1], 1'b1})};
        else            bus_a_i = {8'h00, memb(bus_a_o)};
        bus_d_i = memb(bus_a_o);
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wbyte_of(input logic [127:0] wd, input int nb, input int i);
        return wd[8*(nb-1-i) +: 8];
    endfunction

    task automatic do_xfer(input logic we, input logic [1:0] size, input logic [19:0] addr,
                           input logic region, input logic [127:0] wdata, input logic mux,
                           input logic wide, input logic [2:0] setup, input logic [2:0] hold);
        int nb, bb, nbeats;
        logic two, exp_rw;
        logic [19:0] ak;
        logic [7:0] b0, b1;
        logic [127:0] exp_rd;
        nb = (size == 2'd3) ? 16 : (1 << size);
        two = mux && wide && (size != 2'd0);
        bb = two ? 2 : 1;
        nbeats = nb / bb;
        exp_rw = !we;
        @(negedge clk);
        req_we_i = we; req_size_i = size; req_addr_i = addr; req_region_i = region;
        req_wdata_i = wdata; cfg_mux_i = mux; cfg_wide_i = wide;
        cfg_setup_i = setup; cfg_hold_i = hold; req_i = 1'b1;
        check("R1 ready before accept", ready_o, 1);
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0;
        for (int k = 0; k < nbeats; k++) begin
            ak = addr + 20'(k * bb);
            b0 = wbyte_of(wdata, nb, k * bb);
            b1 = two ? wbyte_of(wdata, nb, k * bb + 1) : b0;
            if (mux) begin
                check("R9 latch strobe cs", bus_cs_o, 2'b10);
                check("R9 latch address", bus_a_o, ak);
                check("R7 rw in latch", bus_rw_o, exp_rw);
                check("R1 busy", ready_o, 0);
                @(negedge clk);
            end
            for (int s = 0; s < setup; s++) begin
                check("R5 setup cs low", bus_cs_o, 0);
                check("R5 setup address", bus_a_o, ak);
                check("R7 rw in setup", bus_rw_o, exp_rw);
                check("R8 oe low in setup", bus_oe_o, 0);
                @(negedge clk);
            end
            if (mux) check("R9 strobe on line 0", bus_cs_o, 2'b01);
            else     check("R11 region select", bus_cs_o, region ? 2'b10 : 2'b01);
            if (we && mux && wide)  check("R10 wide write lanes", bus_a_o, {ak[19:16], b0, b1});
            else if (we && mux)     check("R9 narrow shared write", bus_a_o, {ak[19:8], b0});
            else                    check("R4 beat address", bus_a_o, ak);
            check("R3 data bus", bus_d_o, (we && !mux) ? b0 : 8'h00);
            check("R8 oe in strobe", bus_oe_o, !we);
            check("R7 rw in strobe", bus_rw_o, exp_rw);
            @(negedge clk);
            for (int h = 0; h < hold; h++) begin
                check("R6 hold cs low", bus_cs_o, 0);
                check("R6 hold address", bus_a_o, ak);
                check("R6 hold rw", bus_rw_o, exp_rw);
                @(negedge clk);
            end
        end
        check("R2 ack after last beat", ack_o, 1);
        check("R13 ack cycle bus quiet", {bus_a_o, bus_cs_o, bus_d_o}, 0);
        check("R7 rw released", bus_rw_o, 1);
        if (!we) begin
            exp_rd = '0;
            for (int i = 0; i < nb; i++) exp_rd = {exp_rd[119:0], memb(addr + 20'(i))};
            check(two ? "R10 read assembly" : "R4 read assembly", rdata_o, exp_rd);
        end
        @(negedge clk);
        check("R1 ready after ack", ready_o, 1);
        check("R1 ack dropped", ack_o, 0);
        check("R13 idle bus", {bus_a_o, bus_cs_o, bus_d_o, bus_oe_o}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [19:0] a;
        logic [1:0]  sz;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 reset ready", ready_o, 1);
        check("R12 reset ack", ack_o, 0);
        check("R12 reset bus", {bus_a_o, bus_d_o, bus_cs_o, bus_oe_o}, 0);
        check("R12 reset rw", bus_rw_o, 1);
        rst_n = 1'b1;
        // directed corners
        do_xfer(1, 2'd0, 20'h12345, 1, 128'hC3, 0, 0, 3'd0, 3'd0);            // R11 R3
        do_xfer(0, 2'd1, 20'h00102, 0, '0, 0, 1, 3'd1, 3'd2);                 // R3 wide ignored
        do_xfer(0, 2'd3, 20'hABCD0, 0, '0, 1, 1, 3'd2, 3'd1);                 // R10 line read
        do_xfer(0, 2'd0, 20'h00777, 1, '0, 1, 1, 3'd0, 3'd0);                 // R10 odd byte lane
        do_xfer(0, 2'd0, 20'h00776, 0, '0, 1, 1, 3'd0, 3'd0);                 // R10 even byte lane
        do_xfer(1, 2'd0, 20'h00441, 0, 128'h7E, 1, 1, 3'd1, 3'd0);            // R10 byte replicated
        do_xfer(1, 2'd2, 20'hFFFFC, 1, 128'hDEADBEEF, 1, 0, 3'd7, 3'd7);      // R9 R5 R6 max
        do_xfer(1, 2'd3, 20'hFFFF0, 0, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 0, 0, 3'd0, 3'd1); // R4
        // constrained random
        for (int n = 0; n < 150; n++) begin
            sz = 2'($urandom_range(0, 3));
            a  = 20'($urandom);
            if (sz == 2'd1) a[0] = 1'b0;
            if (sz == 2'd2) a[1:0] = 2'b00;
            if (sz == 2'd3) a[3:0] = 4'h0;
            do_xfer(1'($urandom), sz, a, 1'($urandom), {$urandom, $urandom, $urandom, $urandom},
                    1'($urandom), 1'($urandom), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 3)));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule